// File: doc/BRIEF.md
# Oversampled Serial Character Transmitter

This block turns parallel bytes into asynchronous serial character frames on a single output line. A frame is a run of low start bits, the data bits least-significant first, and a run of high stop bits. The block has no clock of its own for the bit rate. An external rate generator supplies a one-cycle enable pulse at a fixed multiple of the bit rate, and every bit is held on the line for that many enable pulses.

The block has no busy flag. At the end of every frame period it raises a request output for exactly one system-clock cycle, in the cycle that carries the closing enable pulse. A producer that asserts load in that cycle hands over the next byte, and the start bit begins with the following enable pulse. The request keeps pulsing once per frame period while the line is idle, so a producer can join at any pulse. If the request output is wired straight back to load, frames follow each other with no gap beyond the stop bits. A load at any other moment has no effect.

Top module: `uart_frame_tx`

## Requirements
- R1: After a synchronous reset the line is high, and it stays high through any frame period that was not started by a load.
- R2: The line changes only in the cycle after an enable pulse, and every bit lasts exactly OVERSAMPLE enable pulses.
- R3: A loaded frame is START_BITS low bits, then the DATA_BITS data bits with bit 0 first, then STOP_BITS high bits.
- R4: The request is high for one cycle only, in a cycle with an enable pulse, on every OVERSAMPLE*(START_BITS+DATA_BITS+STOP_BITS)-th enable pulse counted from reset, whether the line is idle or busy.
- R5: A load in a request cycle latches the data byte, and the first start bit is on the line from the following enable pulse.
- R6: A load in any cycle without a request has no effect on the line, whatever the data input holds.
- R7: With load tied to the request, frames are sent back to back, each start bit following the last stop bit of the previous frame directly.
- R8: A reset in the middle of a frame returns the line high at once and restarts the frame period count from zero.
- R9: The behaviour holds for other parameter sets, including an oversampling factor of 4 and of 8 and stop-bit counts above one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle enable pulse at OVERSAMPLE times the bit rate |
| load_i | input | 1 | Byte handover strobe, honoured only with load_req_o |
| data_i | input | DATA_BITS | Byte to send |
| txd_o | output | 1 | Serial line, high when idle |
| load_req_o | output | 1 | One-cycle pulse at each frame boundary asking for the next byte |

## Verification
The hard case is the single cycle in which the request, an enable pulse and a load all line up, with loads arriving at other times that must be thrown away. The bench gets there by wiring load to the request output through a per-frame permit, while also firing spurious load pulses with scrambled data on a fixed cycle pattern that lands both inside and outside enable cycles. Frame data sweeps every byte value, some frame periods are left idle, and a reset lands mid-frame, with two lanes of different oversampling factor and frame shape running side by side.

// File: rtl/uart_frame_tx_pkg.sv
package uart_frame_tx_pkg;

  // Which part of the frame the bit position points at.
  typedef enum logic [1:0] {
    SEG_START = 2'd0,
    SEG_DATA  = 2'd1,
    SEG_STOP  = 2'd2
  } seg_e;

  // Counter width for a range of v values, never below one bit.
  function automatic int width_for(input int v);
    return (v < 2) ? 1 : $clog2(v);
  endfunction

endpackage

// File: rtl/uart_tx_timebase.sv
module uart_tx_timebase
  import uart_frame_tx_pkg::*;
#(
  parameter int OVERSAMPLE = 8,
  parameter int START_BITS = 1,
  parameter int DATA_BITS  = 8,
  parameter int STOP_BITS  = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_en,
  output logic bit_adv,
  output logic frame_end,
  output seg_e seg
);

  localparam int FRAME_BITS = START_BITS + DATA_BITS + STOP_BITS;
  localparam int SUB_W      = width_for(OVERSAMPLE);
  localparam int POS_W      = width_for(FRAME_BITS);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVERSAMPLE - 1);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(FRAME_BITS - 1);

  logic [SUB_W-1:0] sub_q;
  logic [POS_W-1:0] pos_q;
  logic             last_sub;
  logic             last_pos;

  assign last_sub  = (sub_q == SUB_LAST);
  assign last_pos  = (pos_q == POS_LAST);
  assign bit_adv   = tick_en & last_sub;
  assign frame_end = bit_adv & last_pos;

  // Free-running enable and bit-position counters; they run while idle too.
  always_ff @(posedge clk) begin
    if (rst) begin
      sub_q <= '0;
      pos_q <= '0;
    end else if (tick_en) begin
      if (last_sub) begin
        sub_q <= '0;
        pos_q <= last_pos ? '0 : pos_q + 1'b1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  always_comb begin
    if (int'(pos_q) < START_BITS)                  seg = SEG_START;
    else if (int'(pos_q) < START_BITS + DATA_BITS) seg = SEG_DATA;
    else                                           seg = SEG_STOP;
  end

  // R4: a frame boundary puts both counters back to the start.
  assert_frame_wraps_R4: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> (pos_q == '0 && sub_q == '0));

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter #(
  parameter int START_BITS = 1,
  parameter int DATA_BITS  = 8,
  parameter int STOP_BITS  = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bit_adv,
  input  logic                 frame_end,
  input  logic                 load_i,
  input  logic [DATA_BITS-1:0] data_i,
  output logic                 txd_o
);

  localparam int FRAME_BITS = START_BITS + DATA_BITS + STOP_BITS;

  logic [FRAME_BITS-1:0] frame_q;
  logic [FRAME_BITS-1:0] fresh;

  // Bit 0 of the register is the bit currently on the line.
  assign fresh = {{STOP_BITS{1'b1}}, data_i, {START_BITS{1'b0}}};
  assign txd_o = frame_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= '1;
    end else if (frame_end) begin
      frame_q <= load_i ? fresh : '1;
    end else if (bit_adv) begin
      frame_q <= {1'b1, frame_q[FRAME_BITS-1:1]};
    end
  end

  // R5: a load taken at the boundary drives the start bit next.
  assert_start_after_load_R5: assert property (@(posedge clk) disable iff (rst)
    (frame_end && load_i) |=> !txd_o);

  // R1: a boundary without a load leaves the line high.
  assert_idle_after_skip_R1: assert property (@(posedge clk) disable iff (rst)
    (frame_end && !load_i) |=> txd_o);

  // R2: the line is steady between bit advances.
  assert_hold_between_bits_R2: assert property (@(posedge clk) disable iff (rst)
    !bit_adv |=> $stable(txd_o));

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_frame_tx_pkg::*;
#(
  parameter int OVERSAMPLE = 8,
  parameter int START_BITS = 1,
  parameter int DATA_BITS  = 8,
  parameter int STOP_BITS  = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick_en,
  input  logic                 load_i,
  input  logic [DATA_BITS-1:0] data_i,
  output logic                 txd_o,
  output logic                 load_req_o
);

  logic bit_adv;
  logic frame_end;
  seg_e seg;

  uart_tx_timebase #(
    .OVERSAMPLE (OVERSAMPLE),
    .START_BITS (START_BITS),
    .DATA_BITS  (DATA_BITS),
    .STOP_BITS  (STOP_BITS)
  ) u_timebase (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .bit_adv   (bit_adv),
    .frame_end (frame_end),
    .seg       (seg)
  );

  uart_tx_shifter #(
    .START_BITS (START_BITS),
    .DATA_BITS  (DATA_BITS),
    .STOP_BITS  (STOP_BITS)
  ) u_shifter (
    .clk       (clk),
    .rst       (rst),
    .bit_adv   (bit_adv),
    .frame_end (frame_end),
    .load_i    (load_i),
    .data_i    (data_i),
    .txd_o     (txd_o)
  );

  assign load_req_o = frame_end;

  // R3: stop positions always carry a high line, loaded or idle.
  assert_stop_high_R3: assert property (@(posedge clk) disable iff (rst)
    (seg == SEG_STOP) |-> txd_o);

  // R4: the request is never raised outside an enable cycle.
  assert_req_in_tick_R4: assert property (@(posedge clk) disable iff (rst)
    load_req_o |-> tick_en);

endmodule

// File: tb/test_uart_frame_tx.sv
module tx_lane #(
  parameter int    F   = 4,
  parameter int    S   = 1,
  parameter int    D   = 8,
  parameter int    P   = 1,
  parameter int    NFR = 300,
  parameter string TAG = ""
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output int   chk,
  output int   err,
  output logic done
);

  localparam int FB = S + D + P;
  localparam int L  = F * FB;

  int           nt = 0;
  int           cyc = 0;
  bit           cur_ld = 1'b0;
  logic [D-1:0] cur_b = '0;
  bit           post_rst = 1'b1;

  logic         boundary_now;
  int           m_next;
  bit           want;
  logic         junk;
  logic         load;
  logic [D-1:0] data;
  logic         txd;
  logic         ldreq;

  assign boundary_now = tick && (((nt + 1) % L) == 0);
  assign m_next       = (nt + 1) / L;
  // Frame 2 and some late frames stay idle; frames 1..256 otherwise sweep all bytes.
  assign want         = !(m_next == 2) && !(m_next > 256 && (m_next % 7) == 3);
  assign junk         = ((cyc % 5) == 2) && !boundary_now;
  assign load         = (ldreq && want) || junk;
  assign data         = boundary_now ? D'(m_next) : (~D'(m_next) ^ D'(cyc));
  assign done         = (nt >= NFR * L);

  uart_frame_tx #(
    .OVERSAMPLE (F),
    .START_BITS (S),
    .DATA_BITS  (D),
    .STOP_BITS  (P)
  ) i_uart_frame_tx (
    .clk        (clk),
    .rst        (rst),
    .tick_en    (tick),
    .load_i     (load),
    .data_i     (data),
    .txd_o      (txd),
    .load_req_o (ldreq)
  );

  // Bench-side model state, advanced from the bench's own view of ticks.
  always @(posedge clk) begin
    if (rst) begin
      nt       <= 0;
      cyc      <= 0;
      cur_ld   <= 1'b0;
      post_rst <= 1'b1;
    end else begin
      cyc <= cyc + 1;
      if (tick) begin
        if (boundary_now) begin
          cur_ld <= want;
          cur_b  <= D'(m_next);
        end
        nt <= nt + 1;
      end
    end
  end

  function automatic logic exp_txd(input int n);
    int p;
    if ((n / L) == 0 || !cur_ld) return 1'b1;
    p = (n % L) / F;
    if (p < S)     return 1'b0;
    if (p < S + D) return cur_b[p - S];
    return 1'b1;
  endfunction

  function automatic string tag_for(input int n);
    int p;
    if (post_rst)                  return "R8 R1";
    if ((n / L) == 0 || !cur_ld)   return "R1 R6";
    p = (n % L) / F;
    if (p < S)                     return "R5 R7";
    if (p < S + D)                 return "R3 R2 R6";
    return "R3 R7";
  endfunction

  initial begin
    chk = 0;
    err = 0;
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk = chk + 1;
      if (txd !== exp_txd(nt)) begin
        err = err + 1;
        $display("FAIL %s %s txd: actual=%b expected=%b tick=%0d", tag_for(nt), TAG,
                 txd, exp_txd(nt), nt);
      end
      chk = chk + 1;
      if (ldreq !== boundary_now) begin
        err = err + 1;
        $display("FAIL R4 %s load_req: actual=%b expected=%b tick=%0d", TAG,
                 ldreq, boundary_now, nt);
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && post_rst) post_rst <= 1'b0;
  end

endmodule

module test_uart_frame_tx;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;

  always #5 clk = ~clk;

  int   chk_a, err_a, chk_b, err_b;
  logic done_a, done_b;
  int   wd_fail = 0;

  // Lane A: factor 4, standard 8-bit frame, every byte value sent.
  tx_lane #(.F(4), .S(1), .D(8), .P(1), .NFR(300), .TAG("F4")) lane_a (
    .clk (clk), .rst (rst), .tick (tick),
    .chk (chk_a), .err (err_a), .done (done_a)
  );

  // Lane B, R9: factor 8 with a 6-bit, two-stop-bit frame.
  tx_lane #(.F(8), .S(1), .D(6), .P(2), .NFR(70), .TAG("F8 R9")) lane_b (
    .clk (clk), .rst (rst), .tick (tick),
    .chk (chk_b), .err (err_b), .done (done_b)
  );

  // Enable pulse on every third cycle.
  initial begin
    for (int k = 0; ; k++) begin
      @(posedge clk);
      #1 tick = ((k % 3) == 0);
    end
  end

  // Power-on reset, then a one-cycle reset in the middle of a frame (R8).
  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    repeat (5003) @(posedge clk);
    #1 rst = 1'b1;
    @(posedge clk);
    #1 rst = 1'b0;
  end

  initial begin
    int wd;
    wd = 0;
    repeat (10) @(posedge clk);
    while (!(done_a && done_b) && wd < 150000) begin
      @(posedge clk);
      wd++;
    end
    if (wd >= 150000) begin
      wd_fail = 1;
      $display("FAIL watchdog: actual=expired expected=finished");
    end
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks",
             err_a + err_b + wd_fail, chk_a + chk_b + 1);
    $finish;
  end

endmodule